// File: doc/BRIEF.md
# Privilege-Checked Thread Identifier Register Bank

This block holds three 32-bit words that an operating system uses to tag the thread or process currently running. It sits inside a system-control register file. A 3-bit selector addresses one of the words, and a single-cycle access strobe, a write/read flag, a privilege flag and write data qualify the access. Each word applies its own rule about which privilege levels may read it and which may write it. An access that breaks the rule is refused at once: the fault output rises, a refused write leaves every word as it was, and a refused read returns zero.

The stored words only keep values for software. They influence no other behaviour. Reads are combinational from the addressed word. A permitted write lands on the clock edge that ends the strobe cycle. Selector codes outside the three assigned ones are undefined. They raise the fault and change nothing.

Top module: `thread_id_bank`

## Requirements
- R1: After reset all three words read as zero.
- R2: Selector 2 (the shared word) can be read and written both when `priv_mode`=0 (user) and when `priv_mode`=1 (privileged), with no fault.
- R3: Selector 3 (the user-readable word) can be read from either level. A write when `priv_mode`=0 raises `fault` and leaves the word unchanged. A write when `priv_mode`=1 succeeds.
- R4: Selector 4 (the privileged word) can be read and written only when `priv_mode`=1. Any user access raises `fault` and leaves the word unchanged.
- R5: A refused read (`acc_wr`=0) drives `rd_data` to zero and raises `fault` in the same cycle as the strobe.
- R6: Selector codes 0, 1, 5, 6 and 7 raise `fault` for a read or a write, return zero and change no word.
- R7: A permitted write (`acc_wr`=1) is visible on the next read after the rising clock edge that ends the strobe cycle. A permitted read shows the addressed word combinationally in the strobe cycle.
- R8: A write to one word leaves the other two words unchanged.
- R9: While `acc_en` is low, `fault` is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Word selector (2, 3 or 4 are assigned) |
| priv_mode | input | 1 | 1 = privileged level, 0 = user level |
| wr_data | input | 32 | Data to store on a permitted write |
| rd_data | output | 32 | Addressed word on a permitted read, otherwise zero |
| fault | output | 1 | High during a refused or undefined access |

## Verification
The bench sweeps every selector code against both privilege levels and both directions. This separates the three permission rules from one another and from the undefined codes. Each write carries a data word derived from its position in the sweep, and all three words are read back at the privileged level afterwards. A refused write shows up as an unchanged word, and a write landing in the wrong slot shows up as a change in one of the other words. All-ones and all-zero data passes check that every bit is stored, and the idle cycle between accesses is checked to confirm that the outputs return to rest.

// File: rtl/tid_pkg.sv
package tid_pkg;

   typedef enum logic [1:0] {
      TID_POL_OPEN      = 2'd0,
      TID_POL_USER_RO   = 2'd1,
      TID_POL_PRIV_ONLY = 2'd2
   } tid_policy_e;

   // Access rule of each slot, counted from the first assigned selector code
   function automatic tid_policy_e tid_slot_policy(input int idx);
      case (idx)
         0:       return TID_POL_OPEN;
         1:       return TID_POL_USER_RO;
         default: return TID_POL_PRIV_ONLY;
      endcase
   endfunction

endpackage

// File: rtl/tid_sel_decode.sv
module tid_sel_decode #(
   parameter int SEL_W    = 3,
   parameter int NUM_REGS = 3,
   parameter int BASE_SEL = 2
) (
   input  logic [SEL_W-1:0]    sel,
   output logic [NUM_REGS-1:0] hit,
   output logic                valid
);
   localparam int LAST_SEL = BASE_SEL + NUM_REGS - 1;

   if (SEL_W < 1) begin : g_bad_w
      $error("tid_sel_decode: SEL_W must be positive");
   end
   if (LAST_SEL >= (1 << SEL_W)) begin : g_bad_range
      $error("tid_sel_decode: selector range exceeds SEL_W");
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      localparam logic [SEL_W-1:0] CODE = SEL_W'(BASE_SEL + i);
      assign hit[i] = (sel == CODE);
   end

   assign valid = |hit;

   always_comb begin
      assert_onehot_hit_R6: assert ($onehot0(hit))
         else $error("selector decode hit more than one slot");
   end
endmodule

// File: rtl/tid_perm_check.sv
module tid_perm_check
   import tid_pkg::*;
#(
   parameter int NUM_REGS = 3
) (
   input  logic                acc_en,
   input  logic                acc_wr,
   input  logic                priv_mode,
   input  logic [NUM_REGS-1:0] hit,
   output logic [NUM_REGS-1:0] rd_grant,
   output logic [NUM_REGS-1:0] wr_grant,
   output logic                deny
);
   if (NUM_REGS < 1) begin : g_bad_n
      $error("tid_perm_check: NUM_REGS must be positive");
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      localparam tid_policy_e POL = tid_slot_policy(i);
      logic rd_ok, wr_ok;
      if (POL == TID_POL_OPEN) begin : g_open
         assign rd_ok = 1'b1;
         assign wr_ok = 1'b1;
      end else if (POL == TID_POL_USER_RO) begin : g_uro
         assign rd_ok = 1'b1;
         assign wr_ok = priv_mode;
      end else begin : g_priv
         assign rd_ok = priv_mode;
         assign wr_ok = priv_mode;
      end
      assign rd_grant[i] = acc_en & ~acc_wr & hit[i] & rd_ok;
      assign wr_grant[i] = acc_en &  acc_wr & hit[i] & wr_ok;
   end

   assign deny = acc_en & ~(|rd_grant) & ~(|wr_grant);

   always_comb begin
      assert_single_grant_R8: assert ($onehot0(rd_grant | wr_grant))
         else $error("more than one slot granted");
   end
endmodule

// File: rtl/tid_word_reg.sv
module tid_word_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   if (DATA_W < 1) begin : g_bad_w
      $error("tid_word_reg: DATA_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end

   assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(d)))
      else $error("granted write did not land");

   assert_hold_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q))
      else $error("word changed without a write");
endmodule

// File: rtl/thread_id_bank.sv
module thread_id_bank #(
   parameter int DATA_W   = 32,
   parameter int SEL_W    = 3,
   parameter int NUM_REGS = 3,
   parameter int BASE_SEL = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [SEL_W-1:0]  acc_sel,
   input  logic              priv_mode,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              fault
);
   localparam int LAST_SEL = BASE_SEL + NUM_REGS - 1;
   localparam logic [SEL_W-1:0] SEL_LO   = SEL_W'(BASE_SEL);
   localparam logic [SEL_W-1:0] SEL_HI   = SEL_W'(LAST_SEL);
   localparam logic [SEL_W-1:0] SEL_PRIV = SEL_W'(BASE_SEL + 2);

   if (NUM_REGS < 3) begin : g_bad_n
      $error("thread_id_bank: three policy slots are required");
   end

   logic [NUM_REGS-1:0]             hit, rd_grant, wr_grant;
   logic                            sel_valid, deny;
   logic [NUM_REGS-1:0][DATA_W-1:0] words_q;

   tid_sel_decode #(.SEL_W(SEL_W), .NUM_REGS(NUM_REGS), .BASE_SEL(BASE_SEL)) u_dec (
      .sel   (acc_sel),
      .hit   (hit),
      .valid (sel_valid)
   );

   tid_perm_check #(.NUM_REGS(NUM_REGS)) u_perm (
      .acc_en    (acc_en),
      .acc_wr    (acc_wr),
      .priv_mode (priv_mode),
      .hit       (hit),
      .rd_grant  (rd_grant),
      .wr_grant  (wr_grant),
      .deny      (deny)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      tid_word_reg #(.DATA_W(DATA_W)) u_word (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_grant[i]),
         .d     (wr_data),
         .q     (words_q[i])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_grant[i]) rd_data = rd_data | words_q[i];
      end
   end

   assign fault = deny;

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_en |-> (!fault && rd_data == '0))
      else $error("outputs active while idle");

   assert_undefined_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && (acc_sel < SEL_LO || acc_sel > SEL_HI)) |-> (fault && !sel_valid))
      else $error("undefined selector accepted");

   assert_user_priv_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !priv_mode && acc_sel == SEL_PRIV) |-> fault)
      else $error("user access to privileged word accepted");

   assert_denied_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr && fault) |-> (rd_data == '0))
      else $error("refused read leaked data");

   assert_denied_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wr && fault) |=> $stable(words_q))
      else $error("refused write changed state");
endmodule

// File: tb/thread_id_bank_bench.sv
`timescale 1ns/1ps
module thread_id_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0, priv_mode = 1'b0;
   logic [2:0]  acc_sel = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        fault;

   int tests = 0, fails = 0;
   bit done = 0;
   logic [31:0] model [3];

   always #4 clk = ~clk;

   thread_id_bank u_thread_id_bank (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_sel(acc_sel), .priv_mode(priv_mode), .wr_data(wr_data),
      .rd_data(rd_data), .fault(fault)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Expected permission from the requirements: R2 shared, R3 user-readable, R4 privileged
   function automatic bit allowed(input int sel, input bit pv, input bit wr);
      case (sel)
         2: return 1'b1;
         3: return wr ? pv : 1'b1;
         4: return pv;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string tag_of(input int sel);
      case (sel)
         2: return "R2";
         3: return "R3";
         4: return "R4";
         default: return "R6";
      endcase
   endfunction

   task automatic access(input int sel, input bit pv, input bit wr, input logic [31:0] d);
      bit ok;
      ok = allowed(sel, pv, wr);
      @(negedge clk);
      acc_en = 1'b1; acc_sel = 3'(sel); priv_mode = pv; acc_wr = wr; wr_data = d;
      #1;
      check({tag_of(sel), " fault"}, {31'd0, fault}, {31'd0, !ok});
      if (!wr) begin
         // R7 combinational read; R5 refused read is zero
         check(ok ? "R7 read value" : "R5 refused read zero", rd_data,
               ok ? model[sel-2] : 32'd0);
      end
      if (wr && ok) model[sel-2] = d;
      @(negedge clk);
      acc_en = 1'b0;
      #1;
      check("R9 idle fault", {31'd0, fault}, 32'd0);
      check("R9 idle data", rd_data, 32'd0);
   endtask

   task automatic readback_all();
      for (int k = 2; k <= 4; k++) access(k, 1'b1, 1'b0, 32'd0);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 3; k++) model[k] = 32'd0;
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset fault", {31'd0, fault}, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      // R1: all words zero after reset
      for (int k = 2; k <= 4; k++) begin
         @(negedge clk);
         acc_en = 1'b1; acc_wr = 1'b0; priv_mode = 1'b1; acc_sel = 3'(k);
         #1;
         check("R1 reset value", rd_data, 32'd0);
         @(negedge clk) acc_en = 1'b0;
      end
      // Sweep: every selector, level and direction; R8 via readback after each write
      for (int s = 0; s < 8; s++) begin
         for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 2; w++) begin
               logic [31:0] d;
               d = 32'h1357_9BDF * 32'(s * 4 + p * 2 + w + 1) ^ 32'(s << 24);
               access(s, p[0], w[0], d);
               if (w == 1) readback_all();
            end
         end
      end
      // Bit coverage with all-ones and all-zero data
      for (int k = 2; k <= 4; k++) begin
         access(k, 1'b1, 1'b1, 32'hFFFF_FFFF);
         readback_all();
         access(k, 1'b1, 1'b1, 32'h0000_0000);
         readback_all();
      end
      // R4 user read of privileged word after a nonzero privileged write
      access(4, 1'b1, 1'b1, 32'hCAFE_0004);
      access(4, 1'b0, 1'b0, 32'd0);
      access(4, 1'b0, 1'b1, 32'h1111_1111);
      readback_all();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule